// File: doc/BRIEF.md
# Two-Stage Address-Pair Filter Lookup

This block resolves the address part of packet classification. For every request it takes a source and a destination IPv4 address and matches each against its own small set of prefixes, choosing the longest matching one. The two resulting slot numbers together select an entry in a pruned pair table. That table holds only filters whose source and destination parts are both specified. When that entry is absent, the block falls back first to a table of source-only filters, then to a table of destination-only filters, and finally to a catch-all pointer. A miss in the pair table is therefore normal and not an error.

The answer is a pointer to a shared group of transport-level rules, which a later matching stage consumes, plus a 2-bit code saying which table produced it. Every lookup takes the same number of cycles whatever the table contents. Software fills all tables through a single write port. It also builds the tables so that each source-only and destination-only slot holds the filter that should cover that prefix.

Top module: `msf_lookup`

## Requirements
- R1: After reset `res_valid` is 0, `req_ready` is 1, `res_code` is 3, `res_ptr` is 0, and every prefix and table entry is invalid. A lookup made then returns code 3 with pointer 0.
- R2: The two address fields are matched independently. A valid prefix of length L matches when the top L bits of the address equal the top L bits of its value, and length 0 matches every address. Among matching slots the longest length wins. Equal lengths go to the lowest slot number.
- R3: When both fields match and the pair entry at address (source slot × NPFX + destination slot) is valid, the result is that entry's pointer with code 0.
- R4: Otherwise, when the source field matched and the source-only entry at the source slot is valid, the result is its pointer with code 1.
- R5: Otherwise, when the destination field matched and the destination-only entry at the destination slot is valid, the result is its pointer with code 2.
- R6: Otherwise the result is the catch-all register with code 3. A field with no matching prefix never selects a pair entry or its own partial entry.
- R7: A request accepted on a rising edge (`req_valid` and `req_ready` both high) raises `res_valid` for exactly one cycle after the second following edge. One request may be accepted every cycle, and results leave in request order.
- R8: `req_ready` is low in every cycle in which `wr_en` is high. A write lands on the edge where `wr_en` is high. `wr_sel` chooses the target: 0 source prefix, 1 destination prefix, 2 pair table, 3 source-only table, 4 destination-only table, 5 catch-all. The slot is `wr_addr[IW-1:0]`, or all of `wr_addr` for the pair table. `wr_data` bit DW-1 is the valid bit. For prefixes, the length sits just below the valid bit and the value in the low AW bits. For table entries, the pointer sits in the low PTRW bits.
- R9: Writing an entry or prefix with its valid bit 0 removes it, so later lookups that used it resolve through the fallback order.
- R10: `res_code` and `res_ptr` keep their values in every cycle in which `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_src | input | AW | Source address |
| req_dst | input | AW | Destination address |
| res_valid | output | 1 | Result present, one cycle |
| res_code | output | 2 | 0 pair, 1 source-only, 2 destination-only, 3 catch-all |
| res_ptr | output | PTRW | Pointer to transport-level rule group |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 3 | Write target select |
| wr_addr | input | 2*IW | Write slot or pair address |
| wr_data | input | DW | Write payload: valid, length, value or pointer |

## Verification
The bench builds the block with NPFX=4, AW=32 and PTRW=6. With four slots per field, every prefix slot and all sixteen pair entries can be filled. Two slots can be given identical lengths to force the lowest-slot rule, and a /0 prefix can be placed beside longer ones. A reference model recomputes each answer from its own copy of the written tables. Streams of back-to-back requests, mixed with writes that add and remove entries, drive every fallback step in turn.

// File: rtl/msf_lookup.sv
module msf_lookup #(
  parameter int NPFX = 8,
  parameter int AW   = 32,
  parameter int PTRW = 8,
  localparam int IW  = $clog2(NPFX),
  localparam int LW  = $clog2(AW + 1),
  localparam int DW  = AW + LW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_src,
  input  logic [AW-1:0]     req_dst,
  output logic              res_valid,
  output logic [1:0]        res_code,
  output logic [PTRW-1:0]   res_ptr,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [2*IW-1:0]   wr_addr,
  input  logic [DW-1:0]     wr_data
);
  localparam int NPAIR = NPFX * NPFX;

  logic [AW-1:0]    s_val [NPFX];
  logic [AW-1:0]    d_val [NPFX];
  logic [LW-1:0]    s_len [NPFX];
  logic [LW-1:0]    d_len [NPFX];
  logic [NPFX-1:0]  s_ok, d_ok;
  logic [PTRW-1:0]  pr_ptr [NPAIR];
  logic [NPAIR-1:0] pr_ok;
  logic [PTRW-1:0]  sp_ptr [NPFX];
  logic [PTRW-1:0]  dp_ptr [NPFX];
  logic [NPFX-1:0]  sp_ok, dp_ok;
  logic [PTRW-1:0]  dflt_ptr;

  logic [IW-1:0] wslot;
  logic          wok;
  assign wslot = wr_addr[IW-1:0];
  assign wok   = wr_data[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ok <= '0; d_ok <= '0; pr_ok <= '0;
      sp_ok <= '0; dp_ok <= '0; dflt_ptr <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: begin
          s_ok[wslot] <= wok;
          s_len[wslot] <= wr_data[AW +: LW];
          s_val[wslot] <= wr_data[AW-1:0];
        end
        3'd1: begin
          d_ok[wslot] <= wok;
          d_len[wslot] <= wr_data[AW +: LW];
          d_val[wslot] <= wr_data[AW-1:0];
        end
        3'd2: begin
          pr_ok[wr_addr] <= wok;
          pr_ptr[wr_addr] <= wr_data[PTRW-1:0];
        end
        3'd3: begin
          sp_ok[wslot] <= wok;
          sp_ptr[wslot] <= wr_data[PTRW-1:0];
        end
        3'd4: begin
          dp_ok[wslot] <= wok;
          dp_ptr[wslot] <= wr_data[PTRW-1:0];
        end
        3'd5: dflt_ptr <= wr_data[PTRW-1:0];
        default: ;
      endcase
    end
  end

  function automatic logic [AW-1:0] pmask(input logic [LW-1:0] n);
    logic [AW-1:0] m;
    m = '0;
    for (int b = 0; b < AW; b++)
      if (b >= AW - int'(n)) m[b] = 1'b1;
    return m;
  endfunction

  logic [NPFX-1:0] s_m, d_m;
  for (genvar i = 0; i < NPFX; i++) begin : g_match
    assign s_m[i] = s_ok[i] && (((req_src ^ s_val[i]) & pmask(s_len[i])) == '0);
    assign d_m[i] = d_ok[i] && (((req_dst ^ d_val[i]) & pmask(d_len[i])) == '0);
  end

  logic          s_hit, d_hit;
  logic [IW-1:0] s_idx, d_idx;
  logic [LW-1:0] s_best, d_best;

  always_comb begin
    s_hit = 1'b0; s_idx = '0; s_best = '0;
    for (int i = 0; i < NPFX; i++)
      if (s_m[i] && (!s_hit || s_len[i] > s_best)) begin
        s_hit = 1'b1; s_idx = IW'(i); s_best = s_len[i];
      end
  end

  always_comb begin
    d_hit = 1'b0; d_idx = '0; d_best = '0;
    for (int i = 0; i < NPFX; i++)
      if (d_m[i] && (!d_hit || d_len[i] > d_best)) begin
        d_hit = 1'b1; d_idx = IW'(i); d_best = d_len[i];
      end
  end

  logic          acc;
  logic          st_v, st_sh, st_dh;
  logic [IW-1:0] st_si, st_di;

  assign req_ready = ~wr_en;
  assign acc       = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_v <= 1'b0; st_sh <= 1'b0; st_dh <= 1'b0;
      st_si <= '0; st_di <= '0;
    end else begin
      st_v <= acc;
      if (acc) begin
        st_sh <= s_hit; st_si <= s_idx;
        st_dh <= d_hit; st_di <= d_idx;
      end
    end
  end

  logic [2*IW-1:0] pidx;
  logic            p_hit, sp_hit, dp_hit;
  logic [1:0]      n_code;
  logic [PTRW-1:0] n_ptr;

  assign pidx   = {st_si, st_di};
  assign p_hit  = st_sh & st_dh & pr_ok[pidx];
  assign sp_hit = st_sh & sp_ok[st_si];
  assign dp_hit = st_dh & dp_ok[st_di];

  always_comb begin
    if (p_hit)       begin n_code = 2'd0; n_ptr = pr_ptr[pidx];  end
    else if (sp_hit) begin n_code = 2'd1; n_ptr = sp_ptr[st_si]; end
    else if (dp_hit) begin n_code = 2'd2; n_ptr = dp_ptr[st_di]; end
    else             begin n_code = 2'd3; n_ptr = dflt_ptr;      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0; res_code <= 2'd3; res_ptr <= '0;
    end else begin
      res_valid <= st_v;
      if (st_v) begin
        res_code <= n_code;
        res_ptr  <= n_ptr;
      end
    end
  end
endmodule

module msf_lookup_chk #(
  parameter int PTRW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            wr_en,
  input logic            res_valid,
  input logic [1:0]      res_code,
  input logic [PTRW-1:0] res_ptr,
  input logic            st_v,
  input logic [PTRW-1:0] dflt_ptr
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> ##2 res_valid);

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |-> ##2 !res_valid);

  assert_write_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !req_ready);

  assert_catchall_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'd3) |-> res_ptr == $past(dflt_ptr));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !st_v |=> ($stable(res_code) && $stable(res_ptr)));
endmodule

bind msf_lookup msf_lookup_chk #(.PTRW(PTRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .wr_en(wr_en), .res_valid(res_valid), .res_code(res_code), .res_ptr(res_ptr),
  .st_v(st_v), .dflt_ptr(dflt_ptr)
);

// File: tb/sim_msf_lookup.sv
`timescale 1ns/1ps
module sim_msf_lookup;
  localparam int NPFX = 4, AW = 32, PTRW = 6;
  localparam int IW = 2, LW = 6, DW = AW + LW + 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [AW-1:0] req_src = '0, req_dst = '0;
  logic res_valid;
  logic [1:0] res_code;
  logic [PTRW-1:0] res_ptr;
  logic wr_en = 0;
  logic [2:0] wr_sel = '0;
  logic [2*IW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;

  always #2.5 clk = ~clk;

  msf_lookup #(.NPFX(NPFX), .AW(AW), .PTRW(PTRW)) u0 (.*);

  int total = 0, bad = 0;
  string phase = "R1";

  // reference tables
  int  m_sval[NPFX], m_slen[NPFX], m_dval[NPFX], m_dlen[NPFX];
  bit  m_sok[NPFX], m_dok[NPFX], m_pok[NPFX*NPFX], m_spok[NPFX], m_dpok[NPFX];
  int  m_pptr[NPFX*NPFX], m_spptr[NPFX], m_dpptr[NPFX], m_dflt;

  function automatic bit pfx_hit(int a, int v, int len);
    if (len == 0) return 1;
    return (a >>> (32 - len)) == (v >>> (32 - len)) ||
           ((32'(a) >> (32 - len)) == (32'(v) >> (32 - len)));
  endfunction

  function automatic int best(int a, bit sd);
    int b = -1, bl = -1;
    for (int i = 0; i < NPFX; i++) begin
      bit ok = sd ? m_dok[i] : m_sok[i];
      int v  = sd ? m_dval[i] : m_sval[i];
      int l  = sd ? m_dlen[i] : m_slen[i];
      if (ok && pfx_hit(a, v, l) && l > bl) begin b = i; bl = l; end
    end
    return b;
  endfunction

  task automatic model(input int s, input int d, output int c, output int p);
    int si = best(s, 0), di = best(d, 1);
    if (si >= 0 && di >= 0 && m_pok[si*NPFX+di]) begin c = 0; p = m_pptr[si*NPFX+di]; end
    else if (si >= 0 && m_spok[si]) begin c = 1; p = m_spptr[si]; end
    else if (di >= 0 && m_dpok[di]) begin c = 2; p = m_dpptr[di]; end
    else begin c = 3; p = m_dflt; end
  endtask

  function automatic string ctag(int c);
    case (c) 0: return "R3"; 1: return "R4"; 2: return "R5"; default: return "R6";
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, phase, act, exp);
    end
  endtask

  // per-clock comparison against the model
  bit p1v = 0, p2v = 0;
  int p1c, p1p, p2c, p2p;
  int last_c = 3, last_p = 0;
  bit run = 0;
  always @(negedge clk) if (run) begin
    int nc, np;
    chk(res_valid == p2v, "R7", res_valid, p2v);
    if (p2v) begin
      chk(res_code == 2'(p2c), ctag(p2c), res_code, p2c);
      chk(res_ptr == PTRW'(p2p), ctag(p2c), res_ptr, p2p);
      last_c = res_code; last_p = res_ptr;
    end else begin
      chk(res_code == 2'(last_c), "R10", res_code, last_c);
      chk(res_ptr == PTRW'(last_p), "R10", res_ptr, last_p);
    end
    p2v = p1v; p2c = p1c; p2p = p1p;
    p1v = req_valid && req_ready;
    if (p1v) begin model(req_src, req_dst, nc, np); p1c = nc; p1p = np; end
  end

  task automatic wr(input int sel, input int addr, input logic [DW-1:0] data);
    @(posedge clk); #1;
    req_valid = 0;
    wr_en = 1; wr_sel = 3'(sel); wr_addr = (2*IW)'(addr); wr_data = data;
    case (sel)
      0: begin m_sok[addr%NPFX] = data[DW-1]; m_slen[addr%NPFX] = data[AW +: LW]; m_sval[addr%NPFX] = data[AW-1:0]; end
      1: begin m_dok[addr%NPFX] = data[DW-1]; m_dlen[addr%NPFX] = data[AW +: LW]; m_dval[addr%NPFX] = data[AW-1:0]; end
      2: begin m_pok[addr] = data[DW-1]; m_pptr[addr] = data[PTRW-1:0]; end
      3: begin m_spok[addr%NPFX] = data[DW-1]; m_spptr[addr%NPFX] = data[PTRW-1:0]; end
      4: begin m_dpok[addr%NPFX] = data[DW-1]; m_dpptr[addr%NPFX] = data[PTRW-1:0]; end
      5: m_dflt = data[PTRW-1:0];
      default: ;
    endcase
    @(negedge clk);
    chk(req_ready == 0, "R8", req_ready, 0);
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic wpfx(int sel, int slot, logic [31:0] v, int len, bit ok);
    wr(sel, slot, {ok, LW'(len), v});
  endtask

  task automatic wtab(int sel, int addr, int p, bit ok);
    wr(sel, addr, {ok, {(DW-1-PTRW){1'b0}}, PTRW'(p)});
  endtask

  task automatic look(logic [31:0] s, logic [31:0] d);
    @(posedge clk); #1;
    req_valid = 1; req_src = s; req_dst = d;
  endtask

  task automatic idle(int n);
    @(posedge clk); #1; req_valid = 0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(res_valid == 0, "R1", res_valid, 0);
    chk(req_ready == 1, "R1", req_ready, 1);
    chk(res_code == 2'd3, "R1", res_code, 3);
    chk(res_ptr == 0, "R1", res_ptr, 0);
    run = 1;
    look(32'h0A010203, 32'hC0A80501);
    idle(3);

    phase = "load";
    wtab(5, 0, 6'h3F, 1);
    wpfx(0, 0, 32'h0A000000, 8, 1);
    wpfx(0, 1, 32'h0A010000, 16, 1);
    wpfx(0, 2, 32'h00000000, 0, 1);
    wpfx(0, 3, 32'h0A010200, 24, 1);
    wpfx(1, 0, 32'hC0A80000, 16, 1);
    wpfx(1, 1, 32'hC0A80500, 24, 1);
    wpfx(1, 2, 32'hAC100000, 12, 1);
    wtab(2, 3*NPFX+1, 1, 1);
    wtab(2, 1*NPFX+0, 2, 1);
    wtab(2, 0*NPFX+2, 3, 1);
    wtab(3, 0, 5, 1);
    wtab(3, 1, 6, 1);
    wtab(4, 2, 9, 1);
    wtab(4, 0, 10, 1);

    phase = "R2 longest";
    look(32'h0A010299, 32'hC0A80577);   // s3,d1 pair
    look(32'h0A01FF00, 32'hC0A80900);   // s1,d0 pair
    look(32'h0A020000, 32'hAC1F0000);   // s0,d2 pair
    look(32'h0A010299, 32'hC0A80900);   // s3,d0 none -> dst-only d0
    look(32'h0AFF0000, 32'h01020304);   // s0, no dst -> src-only
    look(32'h01020304, 32'hAC100001);   // s2 /0 -> dst-only d2
    look(32'h01020304, 32'h08080808);   // s2, no dst -> catch-all
    look(32'h0A010201, 32'h08080808);   // s3 no partial -> catch-all
    idle(3);

    phase = "R9";
    wtab(2, 3*NPFX+1, 1, 0);
    look(32'h0A010299, 32'hC0A80577);
    wtab(3, 1, 6, 0);
    look(32'h0A01FF00, 32'hC0A80577);
    wpfx(0, 2, 32'h00000000, 0, 0);
    look(32'h01020304, 32'hAC100001);
    idle(3);

    phase = "R2 tie";
    wpfx(1, 3, 32'hC0A80500, 24, 1);
    wtab(2, 3*NPFX+3, 20, 1);
    wtab(2, 3*NPFX+1, 21, 1);
    look(32'h0A010211, 32'hC0A80522);
    idle(3);

    phase = "mix";
    wpfx(0, 2, 32'h00000000, 0, 1);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] s, d;
      s = {8'd10, 8'($urandom_range(0, 2)), 8'($urandom_range(1, 3)), 8'($urandom)};
      d = {8'd192, 8'd168, 8'($urandom_range(4, 6)), 8'($urandom)};
      if (k % 5 == 1) s = $urandom;
      if (k % 7 == 2) d = {8'd172, 8'(16 + $urandom_range(0, 31)), 16'($urandom)};
      if (k % 11 == 3) d = $urandom;
      if (k % 40 == 39) begin
        idle(1);
        wtab($urandom_range(2, 4), $urandom_range(0, NPFX*NPFX-1), $urandom_range(0, 63), 1'($urandom));
      end
      look(s, d);
    end
    idle(4);
    run = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule